// File: doc/BRIEF.md
# Four-Phase Interleaved PWM Generator

This block drives a four-branch interleaved boost stage. One shared counter sets the switching period. Each of the four phases produces a main-switch gate with the same duty cycle, and each phase starts a quarter period after the previous one. Each phase also drives a synchronous-rectifier gate. That gate is the complement of its main switch, with a programmable guard interval before and after the main on-time. A zero-crossing flag from the analog side stops a phase's rectifier early and keeps it off until that phase's next period begins, so current cannot reverse through the rectifier.

An upstream controller supplies a duty code in clock counts. It can enable or disable each phase and can ask to skip single pulses. A one-cycle period tick, aligned with the start of phase 0, tells that controller when a new period begins. Every phase takes a new duty code, guard interval, enable and skip request only at the start of its own period, so a change in the middle of a period never cuts a pulse short.

Top module: `quad_phase_pwm`

## Requirements
- R1: While `rst_n` is low at a clock edge, all gate outputs and `period_tick` are low from the next cycle. The period counter restarts, so phase 0 begins its first period on the first edge after reset is released.
- R2: The switching period is 500 clock cycles. `period_tick` is high for exactly one cycle per period, in the same cycle that phase 0's main gate rises.
- R3: Phase k (k = 0..3) begins its period 125*k cycles after phase 0, so the main-gate rising edges of neighbouring phases are 125 cycles apart.
- R4: A phase's main gate is high for D cycles from the start of its period. D is `duty_code` limited to the range 25..450 (5%..90% in 0.2% steps): codes below 25 give 25 and codes above 450 give 450.
- R5: With guard value G taken from `dead_cycles`, the rectifier gate of an active phase is high at period positions D+G through 499-G. A phase's main and rectifier gates are never high in the same cycle.
- R6: If `zc_flag[k]` is sampled high while phase k is at a position at or after D, its rectifier gate is low from the next cycle until the end of that period. A flag sampled at a position below D has no effect.
- R7: If `phase_en[k]` is low, or `skip_req[k]` is high, at the start of phase k's period, both gates of that phase stay low for the whole period.
- R8: Changes to `duty_code`, `dead_cycles`, `phase_en` and `skip_req` take effect for phase k only at the start of its next period. Phase k's gate timing for the current period does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one count = 1/500 period) |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_code | input | 9 | Main on-time in clock counts, limited to 25..450 |
| dead_cycles | input | 4 | Guard interval G around the rectifier on-time |
| phase_en | input | 4 | Per-phase enable, bit k = phase k |
| skip_req | input | 4 | Per-phase request to skip the next pulse |
| zc_flag | input | 4 | Per-phase zero-crossing indication |
| main_gate | output | 4 | Main-switch gates, bit k = phase k |
| rect_gate | output | 4 | Synchronous-rectifier gates, bit k = phase k |
| period_tick | output | 1 | One-cycle pulse at the start of phase 0 |

## Verification
Every gate output and the tick are registered from the counter state and the inputs sampled at the previous edge. A result is therefore due exactly one clock after the edge that sees its stimulus: one cycle for a zero-crossing cut, and one cycle after the start edge of the phase for an enable, skip or duty change. The bench's reference model updates at each rising edge from the same sampled inputs and predicts every output for the cycle that follows. It compares all outputs at the falling edge, where inputs and outputs are stable. Separate edge-to-edge cycle counts confirm the 500-cycle period and the 125-cycle phase spacing.

// File: rtl/qpwm_pkg.sv
// Package qpwm_pkg: shared constants and a helper for the interleaved PWM.
// Assumes the duty range is given in percent of the period counter length.
package qpwm_pkg;

    localparam int unsigned DUTY_MIN_PCT = 5;
    localparam int unsigned DUTY_MAX_PCT = 90;

    // Limit a requested duty count to [lo, hi].
    function automatic logic [15:0] clamp_count(input logic [15:0] req,
                                                input logic [15:0] lo,
                                                input logic [15:0] hi);
        if (req < lo)      return lo;
        else if (req > hi) return hi;
        else               return req;
    endfunction

endpackage

// File: rtl/qpwm_period_ctr.sv
// Module qpwm_period_ctr: free-running modulo-PERIOD counter shared by all
// phases, plus a registered tick in the cycle after the counter reads zero.
// Assumes PERIOD >= 2. Synchronous active-low reset.
module qpwm_period_ctr #(
    parameter int unsigned PERIOD = 500,
    localparam int unsigned CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             tick
);

    // Advance the period counter and register the period-start tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            cnt  <= (cnt == CNT_W'(PERIOD - 1)) ? '0 : cnt + 1'b1;
            tick <= (cnt == '0);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(PERIOD)); // R2
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/qpwm_phase_slice.sv
// Module qpwm_phase_slice: one phase of the interleaved PWM. It derives the
// phase-local position from the shared counter and an OFFSET. At local
// position 0 it latches duty, guard, enable and skip. It drives a registered
// main gate and a complementary rectifier gate that a zero-crossing flag can
// cut off until the phase's next period.
// Assumes duty_in is already limited to [1, PERIOD-1].
module qpwm_phase_slice #(
    parameter int unsigned PERIOD = 500,
    parameter int unsigned OFFSET = 0,
    parameter int unsigned DEAD_W = 4,
    localparam int unsigned CNT_W = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  duty_in,
    input  logic [DEAD_W-1:0] dead_in,
    input  logic              en_in,
    input  logic              skip_in,
    input  logic              zc_in,
    output logic              main_q,
    output logic              rect_q
);

    logic [CNT_W:0]    pos_sum;
    logic [CNT_W:0]    pos;
    logic              at_start;
    logic              act_l;
    logic [CNT_W-1:0]  duty_l;
    logic [DEAD_W-1:0] dead_l;
    logic              zc_cut;
    logic [CNT_W:0]    rect_lo;
    logic [CNT_W:0]    rect_hi;
    logic              in_rect_win;

    // Phase-local position: shared count shifted back by OFFSET, modulo PERIOD.
    always_comb begin
        pos_sum  = {1'b0, cnt} + (CNT_W+1)'(PERIOD - OFFSET);
        pos      = (pos_sum >= (CNT_W+1)'(PERIOD)) ? pos_sum - (CNT_W+1)'(PERIOD) : pos_sum;
        at_start = (pos == '0);
    end

    // Rectifier window bounds from the latched duty and guard interval.
    always_comb begin
        rect_lo     = {1'b0, duty_l} + (CNT_W+1)'(dead_l);
        rect_hi     = (CNT_W+1)'(PERIOD) - (CNT_W+1)'(dead_l);
        in_rect_win = (pos >= rect_lo) && (pos < rect_hi);
    end

    // Latch per-period settings at the start and drive both gates registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_l  <= 1'b0;
            duty_l <= '0;
            dead_l <= '0;
            zc_cut <= 1'b0;
            main_q <= 1'b0;
            rect_q <= 1'b0;
        end else if (at_start) begin
            act_l  <= en_in && !skip_in;
            duty_l <= duty_in;
            dead_l <= dead_in;
            zc_cut <= 1'b0;
            main_q <= en_in && !skip_in;
            rect_q <= 1'b0;
        end else begin
            main_q <= act_l && (pos < {1'b0, duty_l});
            rect_q <= act_l && in_rect_win && !zc_cut && !zc_in;
            if (act_l && zc_in && (pos >= {1'b0, duty_l}))
                zc_cut <= 1'b1;
        end
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_q && rect_q)); // R5
    AST_ZC_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_cut && !at_start) |=> !rect_q); // R6
    AST_IDLE_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !act_l |-> (!main_q && !rect_q)); // R7
    AST_DUTY_HELD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !at_start |=> ($stable(duty_l) && $stable(dead_l) && $stable(act_l))); // R8

endmodule

// File: rtl/quad_phase_pwm.sv
// Module quad_phase_pwm: top of the four-phase interleaved PWM generator.
// One shared period counter feeds NUM_PH phase slices offset by PERIOD/NUM_PH.
// The duty request is limited to DUTY_MIN_PCT..DUTY_MAX_PCT of the period.
// Assumes PERIOD is divisible by NUM_PH and by 100 / gcd for the percent limits.
module quad_phase_pwm
    import qpwm_pkg::*;
#(
    parameter int unsigned PERIOD = 500,
    parameter int unsigned NUM_PH = 4,
    parameter int unsigned DEAD_W = 4,
    localparam int unsigned CNT_W    = $clog2(PERIOD),
    localparam int unsigned PH_STEP  = PERIOD / NUM_PH,
    localparam int unsigned DUTY_MIN = PERIOD * DUTY_MIN_PCT / 100,
    localparam int unsigned DUTY_MAX = PERIOD * DUTY_MAX_PCT / 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  duty_code,
    input  logic [DEAD_W-1:0] dead_cycles,
    input  logic [NUM_PH-1:0] phase_en,
    input  logic [NUM_PH-1:0] skip_req,
    input  logic [NUM_PH-1:0] zc_flag,
    output logic [NUM_PH-1:0] main_gate,
    output logic [NUM_PH-1:0] rect_gate,
    output logic              period_tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_eff;

    // Limit the requested duty to the allowed count range.
    always_comb begin
        duty_eff = CNT_W'(clamp_count(16'(duty_code), 16'(DUTY_MIN), 16'(DUTY_MAX)));
    end

    qpwm_period_ctr #(.PERIOD(PERIOD)) ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt),
        .tick (period_tick)
    );

    for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
        qpwm_phase_slice #(
            .PERIOD(PERIOD),
            .OFFSET(k * PH_STEP),
            .DEAD_W(DEAD_W)
        ) slice_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt),
            .duty_in(duty_eff),
            .dead_in(dead_cycles),
            .en_in  (phase_en[k]),
            .skip_in(skip_req[k]),
            .zc_in  (zc_flag[k]),
            .main_q (main_gate[k]),
            .rect_q (rect_gate[k])
        );
    end

    AST_DUTY_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_eff >= CNT_W'(DUTY_MIN)) && (duty_eff <= CNT_W'(DUTY_MAX))); // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (main_gate == '0 && rect_gate == '0 && !period_tick)); // R1

endmodule

// File: tb/quad_phase_pwm_tb_top.sv
// Bench for quad_phase_pwm: a behavioural per-cycle reference model that is
// compared at every falling edge, plus edge-spacing checks.
module quad_phase_pwm_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] duty_code = 9'd250;
    logic [3:0] dead_cycles = 4'd3;
    logic [3:0] phase_en = 4'hF;
    logic [3:0] skip_req = 4'h0;
    logic [3:0] zc_flag = 4'h0;
    logic [3:0] main_gate;
    logic [3:0] rect_gate;
    logic       period_tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string scen = "R1";

    always #2 clk = ~clk;

    quad_phase_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .duty_code(duty_code), .dead_cycles(dead_cycles),
        .phase_en(phase_en), .skip_req(skip_req), .zc_flag(zc_flag),
        .main_gate(main_gate), .rect_gate(rect_gate), .period_tick(period_tick)
    );

    // Reference model state.
    int  m_cnt;
    bit  m_act [4];
    int  m_duty[4];
    int  m_dead[4];
    bit  m_cut [4];
    logic [3:0] exp_main = 0;
    logic [3:0] exp_rect = 0;
    logic       exp_tick = 0;

    // Reference model: predict the outputs for the cycle after each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            exp_main = 0; exp_rect = 0; exp_tick = 0;
            for (int k = 0; k < 4; k++) begin
                m_act[k] = 0; m_duty[k] = 0; m_dead[k] = 0; m_cut[k] = 0;
            end
        end else begin
            int d;
            d = duty_code;
            if (d < 25) d = 25;
            if (d > 450) d = 450;
            exp_tick = (m_cnt == 0);
            for (int k = 0; k < 4; k++) begin
                int loc;
                loc = (m_cnt - k * 125 + 500) % 500;
                if (loc == 0) begin
                    m_act[k]    = phase_en[k] && !skip_req[k];
                    m_duty[k]   = d;
                    m_dead[k]   = dead_cycles;
                    m_cut[k]    = 0;
                    exp_main[k] = m_act[k];
                    exp_rect[k] = 0;
                end else begin
                    exp_main[k] = m_act[k] && (loc < m_duty[k]);
                    exp_rect[k] = m_act[k] && (loc >= m_duty[k] + m_dead[k])
                                  && (loc < 500 - m_dead[k]) && !m_cut[k] && !zc_flag[k];
                    if (m_act[k] && zc_flag[k] && loc >= m_duty[k]) m_cut[k] = 1;
                end
            end
            m_cnt = (m_cnt + 1) % 500;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (main_gate !== exp_main) begin
                errors++;
                $display("FAIL R4 (scenario %s) main_gate actual %b expected %b at %0t", scen, main_gate, exp_main, $time);
            end
            checks++;
            if (rect_gate !== exp_rect) begin
                errors++;
                $display("FAIL R5 (scenario %s) rect_gate actual %b expected %b at %0t", scen, rect_gate, exp_rect, $time);
            end
            checks++;
            if (period_tick !== exp_tick) begin
                errors++;
                $display("FAIL R2 period_tick actual %b expected %b at %0t", period_tick, exp_tick, $time);
            end
        end
    end

    // Edge-spacing checks for the period (R2) and the phase offset (R3).
    int  cyc = 0;
    int  last_tick = -1;
    int  last_rise0 = -1;
    bit  spacing_on = 0;
    logic [3:0] prev_main = 0;
    always @(negedge clk) begin
        cyc++;
        if (spacing_on && !done) begin
            if (period_tick) begin
                if (last_tick >= 0) begin
                    checks++;
                    if (cyc - last_tick != 500) begin
                        errors++;
                        $display("FAIL R2 tick spacing actual %0d expected 500", cyc - last_tick);
                    end
                end
                last_tick = cyc;
            end
            if (main_gate[0] && !prev_main[0]) last_rise0 = cyc;
            if (main_gate[1] && !prev_main[1] && last_rise0 >= 0) begin
                checks++;
                if (cyc - last_rise0 != 125) begin
                    errors++;
                    $display("FAIL R3 phase spacing actual %0d expected 125", cyc - last_rise0);
                end
            end
        end
        prev_main = main_gate;
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        run(5);
        checks++;
        if (main_gate !== 0 || rect_gate !== 0 || period_tick !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b %b %b expected 0 0 0", main_gate, rect_gate, period_tick);
        end
        rst_n = 1'b1;

        // Nominal: spacing and duty at mid range.
        scen = "R3"; spacing_on = 1;
        run(1600);
        spacing_on = 0;

        // Duty clamp at both ends.
        scen = "R4"; duty_code = 9'd10; run(1100);
        duty_code = 9'd511; run(1100);
        duty_code = 9'd25; run(600);
        duty_code = 9'd450; run(600);

        // Guard interval extremes.
        scen = "R5"; duty_code = 9'd200; dead_cycles = 4'd0; run(1000);
        dead_cycles = 4'd15; run(1000);

        // Mid-period changes of duty and guard.
        scen = "R8";
        for (int i = 0; i < 30; i++) begin
            duty_code = 9'(40 + (i * 53) % 400);
            dead_cycles = 4'(i % 7);
            run(137);
        end
        phase_en = 4'hF; dead_cycles = 4'd3;

        // Enable mask and pulse skipping.
        scen = "R7"; phase_en = 4'b0101; run(1100);
        phase_en = 4'b1010; skip_req = 4'b0010; run(700);
        skip_req = 4'b0000; run(300);
        phase_en = 4'hF;
        for (int i = 0; i < 12; i++) begin
            skip_req = 4'(i * 5);
            run(97);
        end
        skip_req = 0; run(500);

        // Zero-crossing cuts, including flags during the on-time.
        scen = "R6"; duty_code = 9'd150;
        for (int i = 0; i < 60; i++) begin
            run(23 + (i * 17) % 61);
            zc_flag = 4'(i + 1);
            run(1 + i % 3);
            zc_flag = 0;
        end
        run(600);

        // Reset in mid-run restarts the counter.
        scen = "R1"; rst_n = 1'b0; run(3);
        checks++;
        if (main_gate !== 0 || rect_gate !== 0) begin
            errors++;
            $display("FAIL R1 mid-run reset actual %b %b expected 0 0", main_gate, rect_gate);
        end
        rst_n = 1'b1; run(1000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule